// File: doc/BRIEF.md
# SPI ADC Channel Scan Sequencer

This block is the SPI master for a multi-channel successive-approximation converter. A one-cycle start pulse samples a channel-enable mask. The block then sends one 16-bit command frame for each enabled channel, lowest index first, and each frame asks the converter to sample that channel. The converter returns each result one frame later, so the scan ends with one extra read frame that carries an all-zero word.

Each returned frame holds a channel tag and a 12-bit value. The block checks the tag against the channel that was asked for and reports every sample on a valid strobe, together with its channel, its position in the scan and an error flag. The same data is also kept in a small buffer, indexed by scan position, which can be read at any time. A single-cycle done pulse closes the scan.

The command word keeps the converter in normal power mode, with the reference-tied range and straight-binary coding. Its sequence setting is always zero. The two bits of that setting are not adjacent in the word.

Top module: `adc_scan_seq`

## Requirements
- R1: While in reset and right after it, cs_n_o and sclk_o are high, mosi_o is low, and busy_o, done_o and res_valid_o are low.
- R2: A command frame is the 12-bit control word shifted left by 4, with frame bits 3:0 zero. Frame bit 15 is 1 (write). The two sequence bits sit at frame bits 14 and 7 and are both 0. The channel sits at frame bits 12:10 (bit 12 unused when there are 4 channels). The power mode at frame bits 9:8 is 3 (normal). Range at frame bit 5 and coding at frame bit 4 are both 1. For channel c the frame is 16'h8330 | (c << 10).
- R3: Enabled channels are visited in ascending index order, with exactly one command frame for each set mask bit.
- R4: Each scan ends with one trailing frame whose transmitted word is 16'h0000. A scan with N enabled channels therefore uses N+1 frames.
- R5: The SPI bus uses mode 2. sclk_o idles high and is high when cs_n_o falls. MOSI is sent MSB first, changes only on rising sclk and is stable on falling sclk, where MISO is sampled. cs_n_o returns high between frames, and there is no chip-select activity after the trailing frame.
- R6: The result frame that follows a command frame is split into a tag (bits 15:12) and a value (bits 11:0). For each enabled channel, in scan order, res_valid_o pulses once with res_chan_o, res_pos_o (0, 1, ...) and res_data_o.
- R7: When the tag differs from the requested channel zero-extended to 4 bits, res_err_o is 1 for that sample. Otherwise it is 0.
- R8: Each sample's value and error flag are stored at its scan position. rd_data_o and rd_err_o show the entry selected by rd_pos_i combinationally.
- R9: busy_o is high from the cycle after an accepted start until the trailing frame completes. done_o then pulses for exactly one cycle while the bus is idle.
- R10: A start pulse that arrives while busy_o is high is ignored. The running scan and its mask are not changed.
- R11: A start with an all-zero mask gives done_o in the next cycle, with no chip-select activity and no results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle scan request |
| ch_mask_i | input | NUM_CH | Channel-enable mask, sampled with start_i |
| sclk_o | output | 1 | SPI clock, idles high |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial command data |
| miso_i | input | 1 | Serial result data |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| res_valid_o | output | 1 | Sample strobe |
| res_chan_o | output | CH_W | Channel of the sample |
| res_pos_o | output | CH_W | Scan position of the sample |
| res_data_o | output | 12 | Conversion value |
| res_err_o | output | 1 | Tag mismatch on the sample |
| rd_pos_i | input | CH_W | Buffer read position |
| rd_data_o | output | 12 | Buffered value |
| rd_err_o | output | 1 | Buffered error flag |

## Verification
The assertions assume three things. The converter holds MISO steady between rising sclk edges. The mask is sampled only in the cycle of an accepted start. start_i is a synchronous one-cycle pulse. The bench's slave model changes MISO only at chip-select fall and at rising sclk, and it answers each write frame with a tag derived from the command it received. Mask and start change only at falling system-clock edges. A busy start is issued only mid-scan, so the quiet-bus and done properties see the intended sequences.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int FRAME_W = 16;
  localparam int DATA_W  = 12;
  localparam int TAG_W   = 4;
  localparam int PAD_W   = 4;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LAUNCH,
    SQ_WAIT,
    SQ_FINISH
  } seq_state_e;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_SHIFT,
    FR_GAP
  } frame_state_e;

  // Control word assembly; the sequence setting is split over bits 10 and 3.
  function automatic logic [FRAME_W-1:0] build_frame(
    input logic [2:0] chan,
    input logic [1:0] pmode,
    input logic [1:0] seq,
    input logic       rng,
    input logic       coding
  );
    logic [DATA_W-1:0] w;
    w       = '0;
    w[11]   = 1'b1;
    w[10]   = seq[1];
    w[8:6]  = chan;
    w[5:4]  = pmode;
    w[3]    = seq[0];
    w[1]    = rng;
    w[0]    = coding;
    return {w, {PAD_W{1'b0}}};
  endfunction

endpackage

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] remain_i,
  output logic [CH_W-1:0]   next_ch_o,
  output logic              any_o
);

  // Lowest set bit wins: scan from the top so the last hit is the lowest.
  always_comb begin
    next_ch_o = '0;
    any_o     = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (remain_i[i]) begin
        next_ch_o = CH_W'(i);
        any_o     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_spi_frame.sv
module adc_spi_frame
  import adc_scan_pkg::*;
#(
  parameter int CLK_DIV = 2,
  localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
  localparam int BIT_W  = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] tx_frame_i,
  output logic               ready_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_frame_o,
  output logic               sclk_o,
  output logic               cs_n_o,
  output logic               mosi_o,
  input  logic               miso_i
);

  frame_state_e       st_q, st_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic               sclk_q, sclk_d;
  logic               cs_n_q, cs_n_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [FRAME_W-1:0] rx_q, rx_d;
  logic               done_q, done_d;
  logic               tick;

  assign tick = (div_q == DIV_W'(CLK_DIV - 1));

  always_comb begin
    st_d   = st_q;
    div_d  = div_q;
    bit_d  = bit_q;
    sclk_d = sclk_q;
    cs_n_d = cs_n_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    case (st_q)
      FR_IDLE: begin
        if (start_i) begin
          st_d   = FR_SHIFT;
          cs_n_d = 1'b0;
          tx_d   = tx_frame_i;
          div_d  = '0;
          bit_d  = '0;
          sclk_d = 1'b1;
        end
      end
      FR_SHIFT: begin
        if (tick) begin
          div_d = '0;
          if (sclk_q) begin
            sclk_d = 1'b0;
            rx_d   = {rx_q[FRAME_W-2:0], miso_i};
          end else begin
            sclk_d = 1'b1;
            tx_d   = {tx_q[FRAME_W-2:0], 1'b0};
            if (bit_q == BIT_W'(FRAME_W - 1)) begin
              st_d   = FR_GAP;
              cs_n_d = 1'b1;
              done_d = 1'b1;
            end else begin
              bit_d = bit_q + BIT_W'(1);
            end
          end
        end else begin
          div_d = div_q + DIV_W'(1);
        end
      end
      FR_GAP: begin
        if (tick) begin
          st_d  = FR_IDLE;
          div_d = '0;
        end else begin
          div_d = div_q + DIV_W'(1);
        end
      end
      default: st_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      div_q  <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b1;
      cs_n_q <= 1'b1;
      tx_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      sclk_q <= sclk_d;
      cs_n_q <= cs_n_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  assign ready_o    = (st_q == FR_IDLE);
  assign done_o     = done_q;
  assign rx_frame_o = rx_q;
  assign sclk_o     = sclk_q;
  assign cs_n_o     = cs_n_q;
  assign mosi_o     = ~cs_n_q & tx_q[FRAME_W-1];

  // R5: clock idles high whenever the device is deselected
  a_r5_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  // R5: MOSI does not move on the sampling (falling) edge
  a_r5_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> $stable(mosi_o));

  // R5: chip select stays high for at least one cycle after each frame
  a_r5_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |=> cs_n_o);

endmodule

// File: rtl/adc_result_buf.sv
module adc_result_buf
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_pos_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_err_i,
  input  logic [CH_W-1:0]   rd_pos_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_err_o
);

  logic [DATA_W:0] entry_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_entry
    logic hit;
    assign hit = wr_en_i && (wr_pos_i == CH_W'(g));
    always_ff @(posedge clk) begin
      if (hit) begin
        entry_q[g] <= {wr_err_i, wr_data_i};
      end
    end
  end

  assign rd_data_o = entry_q[rd_pos_i][DATA_W-1:0];
  assign rd_err_o  = entry_q[rd_pos_i][DATA_W];

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int         NUM_CH    = 8,
  parameter int         CLK_DIV   = 2,
  parameter logic [1:0] PWR_MODE  = 2'd3,
  parameter logic       RANGE_REF = 1'b1,
  parameter logic       CODE_BIN  = 1'b1,
  localparam int        CH_W      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NUM_CH-1:0] ch_mask_i,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              res_valid_o,
  output logic [CH_W-1:0]   res_chan_o,
  output logic [CH_W-1:0]   res_pos_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic              res_err_o,
  input  logic [CH_W-1:0]   rd_pos_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_err_o
);

  localparam logic [1:0] SEQ_OFF = 2'b00;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  seq_state_e         st_q, st_d;
  logic [NUM_CH-1:0]  remain_q, remain_d;
  logic               sent_vld_q, sent_vld_d;
  logic [CH_W-1:0]    sent_ch_q, sent_ch_d;
  logic               exp_vld_q, exp_vld_d;
  logic [CH_W-1:0]    exp_ch_q, exp_ch_d;
  logic               last_q, last_d;
  logic [CH_W-1:0]    pos_q, pos_d;
  logic               val_q, val_d;
  logic [CH_W-1:0]    rchan_q, rchan_d;
  logic [CH_W-1:0]    rpos_q, rpos_d;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic               rerr_q, rerr_d;

  logic [CH_W-1:0]    next_ch;
  logic               any_left;
  logic               frame_start;
  logic [FRAME_W-1:0] tx_frame;
  logic               f_ready;
  logic               f_done;
  logic [FRAME_W-1:0] rx_frame;
  logic               wr_en;
  logic               tag_bad;

  adc_chan_pick #(.NUM_CH(NUM_CH)) i_pick (
    .remain_i  (remain_q),
    .next_ch_o (next_ch),
    .any_o     (any_left)
  );

  assign tx_frame = any_left ? build_frame(3'(next_ch), PWR_MODE, SEQ_OFF, RANGE_REF, CODE_BIN)
                             : '0;

  adc_spi_frame #(.CLK_DIV(CLK_DIV)) i_frame (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (frame_start),
    .tx_frame_i (tx_frame),
    .ready_o    (f_ready),
    .done_o     (f_done),
    .rx_frame_o (rx_frame),
    .sclk_o     (sclk_o),
    .cs_n_o     (cs_n_o),
    .mosi_o     (mosi_o),
    .miso_i     (miso_i)
  );

  assign tag_bad = (rx_frame[FRAME_W-1 -: TAG_W] != TAG_W'(exp_ch_q));

  always_comb begin
    st_d        = st_q;
    remain_d    = remain_q;
    sent_vld_d  = sent_vld_q;
    sent_ch_d   = sent_ch_q;
    exp_vld_d   = exp_vld_q;
    exp_ch_d    = exp_ch_q;
    last_d      = last_q;
    pos_d       = pos_q;
    val_d       = 1'b0;
    rchan_d     = rchan_q;
    rpos_d      = rpos_q;
    rdata_d     = rdata_q;
    rerr_d      = rerr_q;
    frame_start = 1'b0;
    wr_en       = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (start_i) begin
          if (|ch_mask_i) begin
            st_d       = SQ_LAUNCH;
            remain_d   = ch_mask_i;
            sent_vld_d = 1'b0;
            pos_d      = '0;
          end else begin
            st_d = SQ_FINISH;
          end
        end
      end
      SQ_LAUNCH: begin
        if (f_ready) begin
          frame_start = 1'b1;
          exp_vld_d   = sent_vld_q;
          exp_ch_d    = sent_ch_q;
          sent_vld_d  = any_left;
          sent_ch_d   = next_ch;
          last_d      = ~any_left;
          if (any_left) remain_d[next_ch] = 1'b0;
          st_d = SQ_WAIT;
        end
      end
      SQ_WAIT: begin
        if (f_done) begin
          if (exp_vld_q) begin
            val_d   = 1'b1;
            wr_en   = 1'b1;
            rchan_d = exp_ch_q;
            rpos_d  = pos_q;
            rdata_d = rx_frame[DATA_W-1:0];
            rerr_d  = tag_bad;
            pos_d   = pos_q + CH_W'(1);
          end
          st_d = last_q ? SQ_FINISH : SQ_LAUNCH;
        end
      end
      SQ_FINISH: st_d = SQ_IDLE;
      default:   st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q       <= SQ_IDLE;
      remain_q   <= '0;
      sent_vld_q <= 1'b0;
      sent_ch_q  <= '0;
      exp_vld_q  <= 1'b0;
      exp_ch_q   <= '0;
      last_q     <= 1'b0;
      pos_q      <= '0;
      val_q      <= 1'b0;
      rchan_q    <= '0;
      rpos_q     <= '0;
      rdata_q    <= '0;
      rerr_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      remain_q   <= remain_d;
      sent_vld_q <= sent_vld_d;
      sent_ch_q  <= sent_ch_d;
      exp_vld_q  <= exp_vld_d;
      exp_ch_q   <= exp_ch_d;
      last_q     <= last_d;
      pos_q      <= pos_d;
      val_q      <= val_d;
      rchan_q    <= rchan_d;
      rpos_q     <= rpos_d;
      rdata_q    <= rdata_d;
      rerr_q     <= rerr_d;
    end
  end

  adc_result_buf #(.NUM_CH(NUM_CH)) i_buf (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_pos_i  (pos_q),
    .wr_data_i (rx_frame[DATA_W-1:0]),
    .wr_err_i  (tag_bad),
    .rd_pos_i  (rd_pos_i),
    .rd_data_o (rd_data_o),
    .rd_err_o  (rd_err_o)
  );

  assign busy_o      = (st_q == SQ_LAUNCH) || (st_q == SQ_WAIT);
  assign done_o      = (st_q == SQ_FINISH);
  assign res_valid_o = val_q;
  assign res_chan_o  = rchan_q;
  assign res_pos_o   = rpos_q;
  assign res_data_o  = rdata_q;
  assign res_err_o   = rerr_q;

  // R9: end of scan is signalled only with the bus idle
  a_r9_done_bus_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> (cs_n_o && sclk_o));

  // R6: samples are published in the inter-frame gap
  a_r6_valid_in_gap: assert property (@(posedge clk) disable iff (!rst_int_n)
    res_valid_o |-> cs_n_o);

  // R10: a start during a scan never aborts it
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && start_i) |=> (busy_o || done_o));

  // R11: empty mask finishes in one cycle with no bus activity
  a_r11_empty_mask: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == SQ_IDLE && start_i && ch_mask_i == '0) |=> (done_o && cs_n_o));

endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 8;
  localparam int CH_W       = 3;
  localparam int NVEC       = 6;
  localparam logic [7:0]  VEC_MASK [NVEC] = '{8'h01, 8'h80, 8'hA5, 8'hFF, 8'h60, 8'h12};
  localparam int          VEC_CNT  [NVEC] = '{1, 1, 4, 8, 2, 2};
  localparam logic [11:0] SEED = 12'h123;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [NUM_CH-1:0] ch_mask_i = '0;
  logic sclk, cs_n, mosi;
  logic miso = 1'b0;
  logic busy, done, res_valid, res_err, rd_err;
  logic [CH_W-1:0] res_chan, res_pos;
  logic [CH_W-1:0] rd_pos_i = '0;
  logic [11:0] res_data, rd_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_seq #(.NUM_CH(NUM_CH), .CLK_DIV(2)) i_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ch_mask_i(ch_mask_i),
    .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi), .miso_i(miso),
    .busy_o(busy), .done_o(done), .res_valid_o(res_valid),
    .res_chan_o(res_chan), .res_pos_o(res_pos), .res_data_o(res_data),
    .res_err_o(res_err), .rd_pos_i(rd_pos_i), .rd_data_o(rd_data),
    .rd_err_o(rd_err)
  );

  // converter model
  logic        corrupt_en = 1'b0;
  logic [2:0]  corrupt_ch = 3'd0;
  logic [15:0] s_tx = '0, s_rx = '0, next_resp = '0;
  logic        in_frame = 1'b0;
  logic        sclk_bad = 1'b0;
  int          frame_cnt = 0;
  logic [15:0] frames [64];

  function automatic logic [15:0] resp_for(input logic [15:0] cmd, input logic cen,
                                           input logic [2:0] cch);
    logic [3:0] tag;
    if (!cmd[15]) return 16'h0000;
    tag = {1'b0, cmd[12:10]};
    if (cen && cmd[12:10] == cch) tag = tag ^ 4'b1000;
    return {tag, SEED + 12'(cmd[12:10]) * 12'h111};
  endfunction

  always @(negedge cs_n or posedge cs_n or posedge sclk or negedge sclk) begin
    if (cs_n === 1'b1) begin
      if (in_frame) begin
        in_frame = 1'b0;
        frames[frame_cnt % 64] = s_rx;
        frame_cnt++;
        next_resp = resp_for(s_rx, corrupt_en, corrupt_ch);
      end
    end else if (cs_n === 1'b0) begin
      if (!in_frame) begin
        in_frame = 1'b1;
        if (sclk !== 1'b1) sclk_bad = 1'b1;
        s_tx = next_resp;
        s_rx = '0;
        miso = s_tx[15];
      end else if (sclk) begin
        s_tx = {s_tx[14:0], 1'b0};
        miso = s_tx[15];
      end else begin
        s_rx = {s_rx[14:0], mosi};
      end
    end
  end

  // result monitor
  int         mon_cnt = 0;
  logic [2:0] mon_ch  [64];
  logic [2:0] mon_pos [64];
  logic [11:0] mon_dat [64];
  logic       mon_err [64];
  always @(negedge clk) begin
    if (res_valid) begin
      mon_ch[mon_cnt % 64]  = res_chan;
      mon_pos[mon_cnt % 64] = res_pos;
      mon_dat[mon_cnt % 64] = res_data;
      mon_err[mon_cnt % 64] = res_err;
      mon_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int fbase, mbase, wait_cyc;

  task automatic do_scan(input logic [7:0] m, input bit mid_start, input logic [7:0] m2);
    fbase = frame_cnt;
    mbase = mon_cnt;
    @(negedge clk);
    start_i = 1'b1;
    ch_mask_i = m;
    @(negedge clk);
    start_i = 1'b0;
    ch_mask_i = '0;
    wait_cyc = 0;
    while (!done && wait_cyc < 5000) begin
      @(negedge clk);
      wait_cyc++;
      if (mid_start && wait_cyc == 100) begin
        chk(busy === 1'b1, "R9", "busy mid-scan", busy, 1);
        start_i = 1'b1;
        ch_mask_i = m2;
        @(negedge clk);
        start_i = 1'b0;
        ch_mask_i = '0;
      end
    end
    chk(done === 1'b1, "R9", "done seen", done, 1);
    @(negedge clk);
    chk(done === 1'b0, "R9", "done one cycle", done, 0);
    chk(cs_n === 1'b1 && sclk === 1'b1, "R5", "bus idle after scan", {cs_n, sclk}, 3);
  endtask

  task automatic check_scan(input logic [7:0] m, input int n);
    int k;
    chk(frame_cnt - fbase == n + 1, "R4", "frame count", frame_cnt - fbase, n + 1);
    chk(frames[(fbase + n) % 64] == 16'h0000, "R4", "trailing frame",
        frames[(fbase + n) % 64], 0);
    chk(mon_cnt - mbase == n, "R6", "sample count", mon_cnt - mbase, n);
    k = 0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (m[c]) begin
        logic [15:0] ef;
        ef = 16'h8330 | (16'(c) << 10);
        chk(frames[(fbase + k) % 64] == ef, "R2", "command frame",
            frames[(fbase + k) % 64], ef);
        chk(mon_ch[(mbase + k) % 64] == 3'(c), "R3", "channel order",
            mon_ch[(mbase + k) % 64], c);
        chk(mon_pos[(mbase + k) % 64] == 3'(k), "R6", "position",
            mon_pos[(mbase + k) % 64], k);
        chk(mon_dat[(mbase + k) % 64] == SEED + 12'(c) * 12'h111, "R6", "data",
            mon_dat[(mbase + k) % 64], SEED + 12'(c) * 12'h111);
        chk(mon_err[(mbase + k) % 64] == 1'b0, "R7", "no error",
            mon_err[(mbase + k) % 64], 0);
        rd_pos_i = 3'(k);
        #1;
        chk(rd_data == SEED + 12'(c) * 12'h111 && rd_err == 1'b0, "R8", "buffer",
            rd_data, SEED + 12'(c) * 12'h111);
        k++;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b1 && mosi === 1'b0, "R1", "bus in reset",
        {cs_n, sclk, mosi}, 6);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && res_valid === 1'b0, "R1", "flags after reset",
        {busy, done, res_valid}, 0);

    // table of masks
    for (int v = 0; v < NVEC; v++) begin
      do_scan(VEC_MASK[v], 1'b0, 8'h00);
      check_scan(VEC_MASK[v], VEC_CNT[v]);
    end
    chk(sclk_bad == 1'b0, "R5", "sclk high at select", sclk_bad, 0);

    // R11: empty mask
    do_scan(8'h00, 1'b0, 8'h00);
    chk(wait_cyc == 0, "R11", "done next cycle", wait_cyc, 0);
    chk(frame_cnt == fbase && mon_cnt == mbase, "R11", "no bus activity",
        frame_cnt - fbase, 0);

    // R10: start while busy
    do_scan(8'h03, 1'b1, 8'hF0);
    check_scan(8'h03, 2);
    repeat (200) @(negedge clk);
    chk(frame_cnt - fbase == 3 && busy === 1'b0, "R10", "second start ignored",
        frame_cnt - fbase, 3);

    // R7: tag mismatch on channel 2
    corrupt_en = 1'b1;
    corrupt_ch = 3'd2;
    do_scan(8'h0C, 1'b0, 8'h00);
    chk(mon_err[mbase % 64] == 1'b1, "R7", "mismatch flagged", mon_err[mbase % 64], 1);
    chk(mon_err[(mbase + 1) % 64] == 1'b0, "R7", "match clean",
        mon_err[(mbase + 1) % 64], 0);
    chk(mon_dat[mbase % 64] == SEED + 12'h222, "R7", "data kept", mon_dat[mbase % 64],
        SEED + 12'h222);
    rd_pos_i = 3'd0;
    #1;
    chk(rd_err == 1'b1, "R8", "buffered error", rd_err, 1);
    corrupt_en = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule